// File: doc/BRIEF.md
# Debug Line Timeout Monitor

This block watches a single-wire, open-drain debug line. It works in the target clock domain. It passes the raw line level through a short synchronizer and then measures every low pulse the host drives. A short low pulse is reported as one bit slot. A low pulse that lasts longer than a fixed threshold is reported as a synchronization request. The block then waits for the line to go high again, with no time limit, and fires a strobe that lets the reply logic start the synchronization response.

The block also runs the inactivity timer for the serial link. While the surrounding logic reports that a command or a data read is under way, the block counts the cycles since the most recent falling edge. If the gap grows past the timeout, the block emits a one-cycle soft-reset strobe so that the partial transfer is dropped. In handshake mode the timer is paused from the moment a read request is raised. It starts again only when an acknowledge pulse arrives after the data has become ready, and it counts the full window from that acknowledge. Bit value sampling, command decoding, memory access and the drive timing of the replies belong to other blocks.

Top module: `dbgl_timeout_mon`

## Requirements
- R1: While reset is held and in the cycles right after it, `bit_slot`, `sync_det`, `sync_resp_go` and `soft_rst` are all 0.
- R2: A low pulse on `line_in` lasting 1 to SYNC_LEN (128) cycles gives exactly one `bit_slot` strobe and no `sync_det`. The two strobes are never high together.
- R3: A low pulse lasting more than SYNC_LEN cycles gives exactly one `sync_det` strobe and no `bit_slot`, however long the line then stays low.
- R4: After a `sync_det`, the return of the line to high gives exactly one `sync_resp_go` strobe, with no limit on the wait. No `soft_rst` is raised while the block is waiting for that rising edge, even when `xfer_busy` is 1.
- R5: With `xfer_busy` at 1 and no pause in force, a falling edge no more than TIMEOUT (512) cycles after the previous one raises no `soft_rst`. A gap of more than TIMEOUT cycles raises exactly one single-cycle `soft_rst`, and the counter saturates rather than wrapping.
- R6: While `xfer_busy` is 0, `soft_rst` is never raised, whatever the length of the quiet period.
- R7: With `hs_en` at 1, a rising edge of `rd_pend` pauses the timeout. No `soft_rst` is raised while the pause lasts, for any length of time.
- R8: The pause from R7 ends on an `ack_pulse` that follows a `data_rdy` strobe. From that pulse the timer counts a fresh TIMEOUT window: `soft_rst` follows if no falling edge arrives within TIMEOUT cycles, and does not if one does.
- R9: An `ack_pulse` that arrives before `data_rdy` during a pause has no effect, and the pause stays in force.
- R10: With `hs_en` at 0, `rd_pend` has no effect. A pending read with no further falling edge is dropped by a `soft_rst` once TIMEOUT cycles have passed since the last falling edge.
- R11: The first falling edge after a `soft_rst` is classified as a new bit slot or synchronization request, and it restarts the timeout window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Raw debug line level, asynchronous |
| hs_en | input | 1 | Handshake mode enabled |
| xfer_busy | input | 1 | A command or data transfer is partly done |
| rd_pend | input | 1 | Read command issued; its rising edge starts a pause in handshake mode |
| data_rdy | input | 1 | Strobe: the read data has become ready |
| ack_pulse | input | 1 | Strobe: the acknowledge pulse has been issued |
| bit_slot | output | 1 | Strobe: a short low pulse has ended |
| sync_det | output | 1 | Strobe: a low pulse has passed the synchronization threshold |
| sync_resp_go | output | 1 | Strobe: the line went high after a synchronization request |
| soft_rst | output | 1 | Strobe: inactivity timeout, drop the transfer |

## Verification
The bench sweeps every low-pulse length from 1 to 140 cycles across the bit/sync threshold. An off-by-one in the low counter would misclassify the 128- or 129-cycle pulse, or report both strobes. It sets falling-edge gaps on each side of the 512-cycle limit. A design that counts one cycle too many or too few would fire at 512 or stay silent at 513. A design that wraps its counter would fire again during a long quiet period. The handshake cases check three things: a pause that leaks would reset a read that is waiting for slow data, an acknowledge taken before the data is ready would end the pause too early, and a timer that is not restarted from the acknowledge would fire at the wrong time. Long synchronization holds with the transfer flag set expose a timer that keeps running during the wait.

// File: rtl/dbgl_pkg.sv
package dbgl_pkg;
  typedef enum logic [1:0] {
    PC_IDLE  = 2'd0,
    PC_LOW   = 2'd1,
    PC_SYNCW = 2'd2
  } pc_state_t;
endpackage

// File: rtl/dbgl_sync.sv
module dbgl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic fall,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              lvl_d;
  logic              lvl;

  assign lvl = chain[STAGES-1];

  // line idles high (open drain with pull-up)
  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      lvl_d <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      lvl_d <= lvl;
    end
  end

  assign fall = lvl_d & ~lvl;
  assign rise = ~lvl_d & lvl;
endmodule

// File: rtl/dbgl_pulse_class.sv
module dbgl_pulse_class
  import dbgl_pkg::*;
#(
  parameter int SYNC_LEN = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic fall,
  input  logic rise,
  output logic bit_slot,
  output logic sync_det,
  output logic sync_go,
  output logic in_sync
);
  localparam int LW = $clog2(SYNC_LEN + 1);

  pc_state_t       state;
  logic [LW-1:0]   lowcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= PC_IDLE;
      lowcnt   <= '0;
      bit_slot <= 1'b0;
      sync_det <= 1'b0;
      sync_go  <= 1'b0;
    end else begin
      bit_slot <= 1'b0;
      sync_det <= 1'b0;
      sync_go  <= 1'b0;
      unique case (state)
        PC_IDLE: begin
          if (fall) begin
            state  <= PC_LOW;
            lowcnt <= LW'(1);
          end
        end
        PC_LOW: begin
          if (rise) begin
            bit_slot <= 1'b1;
            state    <= PC_IDLE;
          end else if (lowcnt == LW'(SYNC_LEN)) begin
            sync_det <= 1'b1;
            state    <= PC_SYNCW;
          end else begin
            lowcnt <= lowcnt + 1'b1;
          end
        end
        PC_SYNCW: begin
          if (rise) begin
            sync_go <= 1'b1;
            state   <= PC_IDLE;
          end
        end
        default: state <= PC_IDLE;
      endcase
    end
  end

  assign in_sync = (state == PC_SYNCW);
endmodule

// File: rtl/dbgl_idle_timer.sv
module dbgl_idle_timer #(
  parameter int TIMEOUT = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic fall,
  input  logic in_sync,
  input  logic hs_en,
  input  logic xfer_busy,
  input  logic rd_pend,
  input  logic data_rdy,
  input  logic ack_pulse,
  output logic soft_rst
);
  localparam int TW = $clog2(TIMEOUT + 1);

  logic [TW-1:0] cnt;
  logic          rd_pend_d;
  logic          hold_q;
  logic          ready_q;
  logic          rd_rise;
  logic          ack_ok;
  logic          run;
  logic          fire;

  assign rd_rise = rd_pend & ~rd_pend_d;
  assign ack_ok  = hold_q & ready_q & ack_pulse;
  assign run     = xfer_busy & ~hold_q & ~in_sync;
  assign fire    = run & ~fall & (cnt == TW'(TIMEOUT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend_d <= 1'b0;
      hold_q    <= 1'b0;
      ready_q   <= 1'b0;
      cnt       <= '0;
      soft_rst  <= 1'b0;
    end else begin
      rd_pend_d <= rd_pend;
      soft_rst  <= fire;

      if (fire || ack_ok) begin
        hold_q  <= 1'b0;
        ready_q <= 1'b0;
      end else if (hs_en && rd_rise) begin
        hold_q  <= 1'b1;
        ready_q <= 1'b0;
      end else if (hold_q && data_rdy) begin
        ready_q <= 1'b1;
      end

      if (!run || fall || ack_ok) begin
        cnt <= '0;
      end else if (cnt != TW'(TIMEOUT)) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbgl_timeout_mon.sv
module dbgl_timeout_mon #(
  parameter int SYNC_STAGES = 2,
  parameter int SYNC_LEN    = 128,
  parameter int TIMEOUT     = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  input  logic hs_en,
  input  logic xfer_busy,
  input  logic rd_pend,
  input  logic data_rdy,
  input  logic ack_pulse,
  output logic bit_slot,
  output logic sync_det,
  output logic sync_resp_go,
  output logic soft_rst
);
  logic fall;
  logic rise;
  logic in_sync;

  dbgl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (line_in),
    .fall     (fall),
    .rise     (rise)
  );

  dbgl_pulse_class #(.SYNC_LEN(SYNC_LEN)) u_class (
    .clk      (clk),
    .rst      (rst),
    .fall     (fall),
    .rise     (rise),
    .bit_slot (bit_slot),
    .sync_det (sync_det),
    .sync_go  (sync_resp_go),
    .in_sync  (in_sync)
  );

  dbgl_idle_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .fall      (fall),
    .in_sync   (in_sync),
    .hs_en     (hs_en),
    .xfer_busy (xfer_busy),
    .rd_pend   (rd_pend),
    .data_rdy  (data_rdy),
    .ack_pulse (ack_pulse),
    .soft_rst  (soft_rst)
  );
endmodule

// File: rtl/dbgl_timeout_mon_chk.sv
module dbgl_timeout_mon_chk (
  input logic clk,
  input logic rst,
  input logic xfer_busy,
  input logic bit_slot,
  input logic sync_det,
  input logic sync_resp_go,
  input logic soft_rst
);
  logic pend_sync;

  always_ff @(posedge clk) begin
    if (rst) pend_sync <= 1'b0;
    else if (sync_det) pend_sync <= 1'b1;
    else if (sync_resp_go) pend_sync <= 1'b0;
  end

  assert_bit_or_sync_R2: assert property (@(posedge clk) disable iff (rst)
    !(bit_slot && sync_det));

  assert_sync_single_R3: assert property (@(posedge clk) disable iff (rst)
    sync_det |=> !sync_det);

  assert_resp_after_sync_R4: assert property (@(posedge clk) disable iff (rst)
    sync_resp_go |-> pend_sync);

  assert_srst_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> !soft_rst);

  assert_idle_no_srst_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(xfer_busy) |-> !soft_rst);
endmodule

bind dbgl_timeout_mon dbgl_timeout_mon_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .xfer_busy    (xfer_busy),
  .bit_slot     (bit_slot),
  .sync_det     (sync_det),
  .sync_resp_go (sync_resp_go),
  .soft_rst     (soft_rst)
);

// File: tb/dbgl_timeout_mon_bench.sv
module dbgl_timeout_mon_bench;
  localparam int SYNC_LEN = 128;
  localparam int TIMEOUT  = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_in = 1'b1;
  logic hs_en = 1'b0;
  logic xfer_busy = 1'b0;
  logic rd_pend = 1'b0;
  logic data_rdy = 1'b0;
  logic ack_pulse = 1'b0;
  logic bit_slot, sync_det, sync_resp_go, soft_rst;

  int n_chk = 0;
  int n_fail = 0;
  int n_bit = 0, n_sync = 0, n_go = 0, n_srst = 0;
  int b0, s0, g0, r0;

  always #5 clk = ~clk;

  dbgl_timeout_mon #(.SYNC_LEN(SYNC_LEN), .TIMEOUT(TIMEOUT)) u_dbgl_timeout_mon (
    .clk(clk), .rst(rst), .line_in(line_in), .hs_en(hs_en),
    .xfer_busy(xfer_busy), .rd_pend(rd_pend), .data_rdy(data_rdy),
    .ack_pulse(ack_pulse), .bit_slot(bit_slot), .sync_det(sync_det),
    .sync_resp_go(sync_resp_go), .soft_rst(soft_rst)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (bit_slot)     n_bit++;
      if (sync_det)     n_sync++;
      if (sync_resp_go) n_go++;
      if (soft_rst)     n_srst++;
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic low_pulse(input int len);
    line_in = 1'b0;
    cyc(len);
    line_in = 1'b1;
  endtask

  task automatic snap();
    b0 = n_bit; s0 = n_sync; g0 = n_go; r0 = n_srst;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state
    cyc(4);
    #3;
    chk("R1 outputs in reset", {28'd0, bit_slot, sync_det, sync_resp_go, soft_rst}, 0);
    cyc(1);
    rst = 1'b0;
    cyc(3);
    #3;
    chk("R1 outputs after reset", {28'd0, bit_slot, sync_det, sync_resp_go, soft_rst}, 0);

    // R2 / R3 / R4: sweep of low-pulse lengths across the threshold
    for (int len = 1; len <= 140; len++) begin
      snap();
      low_pulse(len);
      cyc(8);
      chk("R2 bit slot count", n_bit - b0, (len <= SYNC_LEN) ? 1 : 0);
      chk("R3 sync count", n_sync - s0, (len > SYNC_LEN) ? 1 : 0);
      chk("R4 response count", n_go - g0, (len > SYNC_LEN) ? 1 : 0);
    end

    // R4: very long sync hold with transfer flag set
    xfer_busy = 1'b1;
    snap();
    line_in = 1'b0;
    cyc(3000);
    chk("R3 one sync in long hold", n_sync - s0, 1);
    chk("R4 no response while low", n_go - g0, 0);
    chk("R4 no timeout during sync wait", n_srst - r0, 0);
    line_in = 1'b1;
    cyc(8);
    chk("R4 response after release", n_go - g0, 1);
    xfer_busy = 1'b0;
    cyc(4);

    // R5: falling-edge gaps around the timeout
    for (int k = 0; k < 6; k++) begin
      int gap;
      case (k)
        0: gap = 400;
        1: gap = 511;
        2: gap = 512;
        3: gap = 513;
        4: gap = 600;
        default: gap = 2000;
      endcase
      xfer_busy = 1'b1;
      snap();
      low_pulse(2);
      cyc(gap - 2);
      low_pulse(2);
      xfer_busy = 1'b0;
      cyc(6);
      chk("R5 timeout strobes for gap", n_srst - r0, (gap > TIMEOUT) ? 1 : 0);
    end

    // R6: no timeout while no transfer in progress
    snap();
    low_pulse(2);
    cyc(2000);
    chk("R6 idle no timeout", n_srst - r0, 0);

    // R7 / R9 / R8: handshake pause and re-arm
    hs_en = 1'b1;
    xfer_busy = 1'b1;
    snap();
    low_pulse(2);
    rd_pend = 1'b1;
    cyc(1500);
    chk("R7 paused no timeout", n_srst - r0, 0);
    ack_pulse = 1'b1; cyc(1); ack_pulse = 1'b0;
    cyc(1000);
    chk("R9 early ack ignored", n_srst - r0, 0);
    data_rdy = 1'b1; cyc(1); data_rdy = 1'b0;
    cyc(800);
    chk("R7 still paused after data ready", n_srst - r0, 0);
    ack_pulse = 1'b1; cyc(1); ack_pulse = 1'b0;
    rd_pend = 1'b0;
    cyc(500);
    chk("R8 no timeout inside window", n_srst - r0, 0);
    cyc(30);
    chk("R8 timeout after ack window", n_srst - r0, 1);
    xfer_busy = 1'b0;
    cyc(4);

    // R8: falling edge inside the window after ack
    xfer_busy = 1'b1;
    snap();
    low_pulse(2);
    rd_pend = 1'b1;
    cyc(50);
    data_rdy = 1'b1; cyc(1); data_rdy = 1'b0;
    ack_pulse = 1'b1; cyc(1); ack_pulse = 1'b0;
    rd_pend = 1'b0;
    cyc(300);
    low_pulse(2);
    cyc(400);
    chk("R8 retrieval edge in window", n_srst - r0, 0);
    xfer_busy = 1'b0;
    hs_en = 1'b0;
    cyc(4);

    // R10: handshake off, read pending is dropped on timeout
    xfer_busy = 1'b1;
    snap();
    low_pulse(2);
    rd_pend = 1'b1;
    cyc(505);
    chk("R10 no timeout before limit", n_srst - r0, 0);
    cyc(20);
    chk("R10 read dropped after limit", n_srst - r0, 1);
    rd_pend = 1'b0;

    // R11: first edge after soft reset starts fresh
    snap();
    low_pulse(2);
    cyc(6);
    chk("R11 bit after soft reset", n_bit - b0, 1);
    cyc(505);
    chk("R11 window restarted", n_srst - r0, 0);
    xfer_busy = 1'b0;
    snap();
    low_pulse(150);
    cyc(8);
    chk("R11 sync after soft reset", n_sync - s0, 1);

    summary();
    $finish;
  end
endmodule